// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Timing Tracker

This block sits inside an SDRAM controller. For every bank it keeps the timing that follows a read with auto-precharge, so the controller knows when that bank may be activated again. It receives one decoded command per clock, together with a bank number, the programmed CAS latency (2 or 3) and a burst-length code.

The data burst of a read issued in cycle R ends on the beat at R + CL + BL - 1. The device begins its internal precharge CL - 1 cycles before that beat, which places the start exactly BL cycles after the read for either latency. The start cannot come before the minimum active-to-precharge time (T_RAS cycles after the bank's activate), so the later of the two cycles is used. A recovery gap of T_APR cycles then has to pass before the bank reports itself ready for a new activate. Commands that break these rules are flagged, and they are not acted on.

Top module: `sdram_apre_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, every bit of `bank_ready` is 1, and `pre_start` and `cmd_illegal` are 0. Reset is synchronous and active high.
- R2: Command codes are 0 no-op, 1 activate, 2 read, 3 read with auto-precharge, 4 precharge and 5 write. An activate to a bank whose `bank_ready` bit is 1 opens that bank, and the bit is 0 in the next cycle.
- R3: For a read with auto-precharge in cycle R to an open bank, the burst length is 1, 2, 4 or 8 for `bl_code` values 0 to 3. The start cycle is the final beat minus (CL - 1), which is R + BL for `cl3` = 0 (CL 2) and for `cl3` = 1 (CL 3). In the start cycle, `pre_start` for that bank pulses high for exactly one cycle, unless R4 moves it.
- R4: If the bank's activate came in cycle A and A + T_RAS is later than R + BL, the pulse happens in cycle A + T_RAS instead.
- R5: `bank_ready` for the bank rises T_APR cycles after its `pre_start` pulse. It then stays high until an activate is accepted.
- R6: A non-NOP command (codes 1 to 5) to a bank whose precharge is pending, or whose recovery gap has not finished, makes `cmd_illegal` high in the next cycle. This includes an activate.
- R7: A command flagged as illegal leaves the bank's timing unchanged: the pulse and ready cycles stay where R3 to R5 put them.
- R8: An activate to an open bank is illegal. So is a read, a read with auto-precharge or a write to a bank that is ready. Each makes `cmd_illegal` high in the next cycle. An explicit precharge to an open bank closes it, and `bank_ready` is high in the next cycle.
- R9: Banks are independent. Commands to one bank never move the pulse or ready cycles of another.
- R10: The burst length is taken from `bl_code` only in the cycle of the read with auto-precharge. Later changes to `bl_code` do not move that bank's pulse.
- R11: Codes 6 and 7 behave as no-ops. They never make `cmd_illegal` high and never change any bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Decoded command code (see R2) |
| cmd_bank | input | 2 | Target bank of `cmd` |
| cl3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| bl_code | input | 2 | Burst length code: 1, 2, 4, 8 |
| bank_ready | output | 4 | Per-bank ready-for-activate flag |
| pre_start | output | 4 | Per-bank pulse in the cycle the internal precharge starts |
| cmd_illegal | output | 1 | High in the cycle after a rejected command |

## Verification
The two timing outputs come straight from registered state. The precharge pulse is due max(R + BL, A + T_RAS) cycles into the run, and the ready flag is due T_APR cycles after that pulse. The illegal flag is registered, so it is due exactly one cycle after the command that causes it. The bench keeps a behavioural model that works in absolute cycle numbers. It compares all three outputs once per clock, at the falling edge and before the next command is driven, so each expected value is tied to the cycle in which the model predicts it.

// File: rtl/sdram_apre_tracker.sv
module sdram_apre_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int T_RAS     = 7,
  parameter int T_APR     = 2,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int RW = $clog2(T_RAS + 1),
  localparam int AW = $clog2(T_APR + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           cmd,
  input  logic [BW-1:0]        cmd_bank,
  input  logic                 cl3,
  input  logic [1:0]           bl_code,
  output logic [NUM_BANKS-1:0] bank_ready,
  output logic [NUM_BANKS-1:0] pre_start,
  output logic                 cmd_illegal
);

  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_RDA = 3'd3,
                         C_PRE = 3'd4, C_WR = 3'd5;
  localparam logic [1:0] S_IDLE = 2'd0, S_OPEN = 2'd1,
                         S_PEND = 2'd2, S_RECOV = 2'd3;

  logic [3:0] beats, cl_v, last_beat, lead, gap;
  assign beats     = 4'd1 << bl_code;
  assign cl_v      = cl3 ? 4'd3 : 4'd2;
  assign last_beat = cl_v + beats - 4'd1;
  assign lead      = cl_v - 4'd1;
  assign gap       = last_beat - lead;

  logic real_cmd, is_rdwr;
  assign real_cmd = (cmd >= C_ACT) && (cmd <= C_WR);
  assign is_rdwr  = (cmd == C_RD) || (cmd == C_RDA) || (cmd == C_WR);

  logic [NUM_BANKS-1:0] bad;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [1:0]    st;
    logic [RW-1:0] ras_cnt;
    logic [3:0]    pend_cnt;
    logic [AW-1:0] rec_cnt;
    logic hit, ras_met, ready, busy, go;

    assign hit     = (cmd_bank == BW'(b));
    assign ras_met = ras_cnt >= RW'(T_RAS);
    assign ready   = (st == S_IDLE) || (st == S_RECOV && rec_cnt == '0);
    assign busy    = (st == S_PEND) || (st == S_RECOV && rec_cnt != '0);
    assign go      = (st == S_PEND) && (pend_cnt == 4'd0) && ras_met;

    assign bad[b] = hit && real_cmd &&
                    (busy || (ready && is_rdwr) || (st == S_OPEN && cmd == C_ACT));
    assign bank_ready[b] = ready;
    assign pre_start[b]  = go;

    always_ff @(posedge clk) begin
      if (rst) begin
        st       <= S_IDLE;
        ras_cnt  <= '0;
        pend_cnt <= '0;
        rec_cnt  <= '0;
      end else begin
        if (hit && cmd == C_ACT && ready) ras_cnt <= RW'(1);
        else if (!ras_met)                ras_cnt <= ras_cnt + RW'(1);

        case (st)
          S_IDLE: if (hit && cmd == C_ACT) st <= S_OPEN;
          S_OPEN: begin
            if (hit && cmd == C_RDA) begin
              st       <= S_PEND;
              pend_cnt <= gap - 4'd1;
            end else if (hit && cmd == C_PRE) begin
              st <= S_IDLE;
            end
          end
          S_PEND: begin
            if (go) begin
              st      <= S_RECOV;
              rec_cnt <= AW'(T_APR - 1);
            end else if (pend_cnt != 4'd0) begin
              pend_cnt <= pend_cnt - 4'd1;
            end
          end
          default: begin
            if (rec_cnt != '0)           rec_cnt <= rec_cnt - AW'(1);
            else if (hit && cmd == C_ACT) st <= S_OPEN;
            else                          st <= S_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_illegal <= 1'b0;
    else     cmd_illegal <= |bad;
  end

endmodule

module sdram_apre_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BW = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           cmd,
  input logic [BW-1:0]        cmd_bank,
  input logic [NUM_BANKS-1:0] bank_ready,
  input logic [NUM_BANKS-1:0] pre_start,
  input logic                 cmd_illegal
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_a
    logic act_b, rd_b;
    assign act_b = (cmd == 3'd1) && (cmd_bank == BW'(b));
    assign rd_b  = (cmd == 3'd2) && (cmd_bank == BW'(b));

    p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      pre_start[b] |=> !pre_start[b]);
    p_pre_not_ready_r5: assert property (@(posedge clk) disable iff (rst)
      pre_start[b] |-> !bank_ready[b]);
    p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
      (act_b && bank_ready[b]) |=> !bank_ready[b]);
    p_ready_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (bank_ready[b] && !act_b) |=> bank_ready[b]);
    p_act_busy_r6: assert property (@(posedge clk) disable iff (rst)
      (act_b && !bank_ready[b]) |=> cmd_illegal);
    p_read_closed_r8: assert property (@(posedge clk) disable iff (rst)
      (rd_b && bank_ready[b]) |=> cmd_illegal);
  end

  p_spare_codes_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd0 || cmd == 3'd6 || cmd == 3'd7) |=> !cmd_illegal);
endmodule

bind sdram_apre_tracker sdram_apre_tracker_chk #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank),
  .bank_ready(bank_ready), .pre_start(pre_start), .cmd_illegal(cmd_illegal)
);

// File: tb/sdram_apre_tracker_bench.sv
module sdram_apre_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int TRAS = 7;
  localparam int TAPR = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [1:0] cmd_bank = 2'd0, bl_code = 2'd0;
  logic cl3 = 1'b0;
  logic [NB-1:0] bank_ready, pre_start;
  logic cmd_illegal;

  sdram_apre_tracker #(.NUM_BANKS(NB), .T_RAS(TRAS), .T_APR(TAPR)) u_sdram_apre_tracker (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cl3(cl3),
    .bl_code(bl_code), .bank_ready(bank_ready), .pre_start(pre_start),
    .cmd_illegal(cmd_illegal));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int mst[NB], act_t[NB], start_t[NB];
  bit ill_q = 0;

  task automatic cmp(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input int b, input logic [1:0] blc, input logic clv);
    logic [NB-1:0] er, ep;
    int ill, bl, s0;
    for (int k = 0; k < NB; k++) begin
      er[k] = (mst[k] == 0) || (mst[k] == 2 && cyc >= start_t[k] + TAPR);
      ep[k] = (mst[k] == 2) && (cyc == start_t[k]);
    end
    cmp("R5 bank_ready", bank_ready, er);
    cmp("R3/R4 pre_start", pre_start, ep);
    cmp("R6/R8 cmd_illegal", {{(NB-1){1'b0}}, cmd_illegal}, {{(NB-1){1'b0}}, ill_q});
    cmd = c; cmd_bank = 2'(b); bl_code = blc; cl3 = clv;
    ill = 0;
    if (c >= 3'd1 && c <= 3'd5) begin
      if (mst[b] == 2 && cyc < start_t[b] + TAPR) ill = 1;
      else if (mst[b] != 1) begin
        if (c == 3'd1) begin mst[b] = 1; act_t[b] = cyc; end
        else if (c == 3'd4) mst[b] = 0;
        else ill = 1;
      end else begin
        if (c == 3'd1) ill = 1;
        else if (c == 3'd3) begin
          bl = 1 << blc;
          s0 = cyc + bl;
          start_t[b] = (s0 > act_t[b] + TRAS) ? s0 : act_t[b] + TRAS;
          mst[b] = 2;
        end else if (c == 3'd4) mst[b] = 0;
      end
    end
    ill_q = (ill != 0);
    cyc++;
    @(negedge clk);
  endtask

  task automatic nops(input int k);
    for (int i = 0; i < k; i++) step(3'd0, 0, bl_code, cl3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NB; k++) begin mst[k] = 0; act_t[k] = 0; start_t[k] = 0; end
    repeat (2) @(negedge clk);
    cmp("R1 reset ready", bank_ready, {NB{1'b1}});
    cmp("R1 reset pre_start", pre_start, '0);
    cmp("R1 reset illegal", {{(NB-1){1'b0}}, cmd_illegal}, '0);
    rst = 1'b0;
    // R1 first cycle after reset is compared inside the first step
    // R3: BL4 CL2, read late so tRAS already met
    step(3'd1, 0, 2'd2, 1'b0); nops(9);
    step(3'd3, 0, 2'd2, 1'b0); nops(8);
    // R4: BL4 CL3, read right after activate, start pushed to tRAS
    step(3'd1, 1, 2'd2, 1'b1);
    step(3'd3, 1, 2'd2, 1'b1);
    // R6/R7: activate and precharge during pending/recovery
    nops(3); step(3'd1, 1, 2'd2, 1'b1); step(3'd4, 1, 2'd2, 1'b1);
    step(3'd7, 1, 2'd2, 1'b1); nops(6);
    // R8: read to ready bank, double activate, precharge closes
    step(3'd2, 2, 2'd0, 1'b0); step(3'd1, 2, 2'd0, 1'b0);
    step(3'd1, 2, 2'd0, 1'b0); step(3'd4, 2, 2'd0, 1'b0); nops(2);
    // R10/R9: BL8 on bank3 with bl_code changing after, bank0 BL1 alongside
    step(3'd1, 3, 2'd3, 1'b0); step(3'd1, 0, 2'd0, 1'b0); nops(8);
    step(3'd3, 3, 2'd3, 1'b1);
    step(3'd3, 0, 2'd0, 1'b0);
    for (int i = 0; i < 12; i++) step(3'd6, i % NB, 2'(i), 1'(i)); // R11
    nops(6);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      step((r < 6) ? 3'(r) : ((r == 15) ? 3'd7 : 3'd0),
           $urandom_range(0, NB - 1), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    nops(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule